// File: doc/BRIEF.md
# DMA Hang Signature Detector

This block decides whether the transmit DMA queue logic has locked up in one of two known hang patterns. It watches four 32-bit debug status words that the queue logic drives every clock. On a start request it takes a snapshot of the four words. It then compares the snapshot with the live words for a fixed number of following clocks. Any movement on any word means the queue logic is still running, so the check ends at once with a no-hang result.

If the words stay frozen for the whole window, the snapshot is classified against two fixed signatures. The first signature is built from per-channel chain states and a completion state. The second is built from three queue state fields. The result comes out with a one-cycle done pulse.

A skip input lets the caller bypass the whole check when a baseband hang is already known. In that case the result is no-hang one clock after start.

Top module: `dma_stall_classifier`

## Requirements
- R1: While reset is high, and on the first cycle after it, `done_o` is 0 and `result_o` is 0.
- R2: When `start_i` is high and `skip_i` is low in an idle cycle, the four words are captured at that edge. The live words are then compared with the snapshot at each of the next HOLD (default 50) edges. If any word differs at the k-th of these edges, `done_o` is high after that edge and `result_o` is 0 (no hang).
- R3: If all four words match the snapshot at all HOLD comparison edges, `done_o` is high after the HOLD-th edge and `result_o` carries the classification.
- R4: Signature 1 needs two things at once. First, one of ten 5-bit chain fields must equal 6: word 4 bits [5i+4:5i] for i = 0..5, or word 5 bits [5i+4:5i] for i = 0..3. Second, word 6 bits [1:0] must equal 1. Other bits of words 4, 5 and 6 are ignored.
- R5: Signature 2 needs word 3 bits [21:18] = 9, bits [25:22] = 8 and bits [28:26] = 4, all at once.
- R6: The result codes are 0 for no hang, 1 for signature 1, 2 for signature 2 and 3 for unknown hang. Signature 1 takes priority when both signatures match. A frozen snapshot that matches neither gives 3.
- R7: `start_i` with `skip_i` high in an idle cycle gives `done_o` high with `result_o` = 0 one clock later, and no window is run.
- R8: `done_o` is high for exactly one cycle per check. `result_o` keeps its value until the next done.
- R9: `start_i` is ignored while a check window is in progress, whatever the value of `skip_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a hang check (taken in idle only) |
| skip_i | input | 1 | With start, return no-hang without checking |
| dbg3_i | input | 32 | Debug word 3: queue stitch, fetch and complete states |
| dbg4_i | input | 32 | Debug word 4: six chain-state fields |
| dbg5_i | input | 32 | Debug word 5: four chain-state fields |
| dbg6_i | input | 32 | Debug word 6: completion state in bits [1:0] |
| done_o | output | 1 | One-cycle pulse when a result is ready |
| result_o | output | 2 | 0 none, 1 signature 1, 2 signature 2, 3 unknown |

## Verification
Call the edge that takes start E0. A skipped check gives its done after E0. A change presented before edge Ek gives done after Ek. A frozen window gives done after E50. The bench drives and samples only on falling edges, counts falling edges from E0, and expects `done_o` low at every count before the due one. It then checks the code at the due count and a low `done_o` one count later. A start pulse in the middle of a window must leave the due count and the code unchanged.

// File: rtl/stall_pkg.sv
package stall_pkg;
  localparam int DBG_W        = 32;
  localparam int CHAIN_W      = 5;
  localparam int CHAINS_W4    = 6;
  localparam int CHAINS_W5    = 4;
  localparam int CMPL_LSB     = 0;
  localparam int CMPL_W       = 2;
  localparam int STITCH_LSB   = 18;
  localparam int STITCH_W     = 4;
  localparam int FETCH_LSB    = 22;
  localparam int FETCH_W      = 4;
  localparam int QDONE_LSB    = 26;
  localparam int QDONE_W      = 3;

  localparam logic [CHAIN_W-1:0]  SIG1_CHAIN  = 5'h6;
  localparam logic [CMPL_W-1:0]   SIG1_CMPL   = 2'h1;
  localparam logic [STITCH_W-1:0] SIG2_STITCH = 4'h9;
  localparam logic [FETCH_W-1:0]  SIG2_FETCH  = 4'h8;
  localparam logic [QDONE_W-1:0]  SIG2_QDONE  = 3'h4;

  typedef enum logic [1:0] {
    RES_NONE    = 2'd0,
    RES_SIG1    = 2'd1,
    RES_SIG2    = 2'd2,
    RES_UNKNOWN = 2'd3
  } stall_res_e;

  typedef struct packed {
    logic [DBG_W-1:0] w3;
    logic [DBG_W-1:0] w4;
    logic [DBG_W-1:0] w5;
    logic [DBG_W-1:0] w6;
  } dbg_snap_t;
endpackage

// File: rtl/stall_snapshot.sv
module stall_snapshot
  import stall_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      capture,
  input  dbg_snap_t live,
  output dbg_snap_t held,
  output logic      moved
);
  always_ff @(posedge clk) begin
    if (rst) held <= '0;
    else if (capture) held <= live;
  end

  assign moved = (held != live);

  // R2
  snap_load_chk: assert property (@(posedge clk) disable iff (rst)
    capture |=> (held == $past(live)));
endmodule

// File: rtl/stall_window_counter.sv
module stall_window_counter #(
  parameter int HOLD = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic enable,
  output logic last
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LAST_VAL = CW'(HOLD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (enable && cnt != LAST_VAL) cnt <= cnt + 1'b1;
  end

  assign last = enable && (cnt == LAST_VAL);

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    enable |-> (cnt <= LAST_VAL));
endmodule

// File: rtl/stall_sig_matcher.sv
module stall_sig_matcher
  import stall_pkg::*;
(
  input  dbg_snap_t  snap,
  output stall_res_e code
);
  logic [CHAINS_W4-1:0] hit4;
  logic [CHAINS_W5-1:0] hit5;

  for (genvar i = 0; i < CHAINS_W4; i++) begin : g_w4
    assign hit4[i] = (snap.w4[CHAIN_W*i +: CHAIN_W] == SIG1_CHAIN);
  end
  for (genvar j = 0; j < CHAINS_W5; j++) begin : g_w5
    assign hit5[j] = (snap.w5[CHAIN_W*j +: CHAIN_W] == SIG1_CHAIN);
  end

  logic chain_ok, cmpl_ok, sig1, sig2;
  assign chain_ok = |{hit4, hit5};
  assign cmpl_ok  = (snap.w6[CMPL_LSB +: CMPL_W] == SIG1_CMPL);
  assign sig1     = chain_ok && cmpl_ok;
  assign sig2     = (snap.w3[STITCH_LSB +: STITCH_W] == SIG2_STITCH) &&
                    (snap.w3[FETCH_LSB  +: FETCH_W]  == SIG2_FETCH)  &&
                    (snap.w3[QDONE_LSB  +: QDONE_W]  == SIG2_QDONE);

  always_comb begin
    if (sig1)      code = RES_SIG1;
    else if (sig2) code = RES_SIG2;
    else           code = RES_UNKNOWN;
  end

  logic unused_bits;
  assign unused_bits = ^{snap.w3, snap.w4, snap.w5, snap.w6};
endmodule

// File: rtl/dma_stall_classifier.sv
module dma_stall_classifier
  import stall_pkg::*;
#(
  parameter int HOLD = 50
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             skip_i,
  input  logic [DBG_W-1:0] dbg3_i,
  input  logic [DBG_W-1:0] dbg4_i,
  input  logic [DBG_W-1:0] dbg5_i,
  input  logic [DBG_W-1:0] dbg6_i,
  output logic             done_o,
  output logic [1:0]       result_o
);
  typedef enum logic {ST_IDLE, ST_WATCH} st_e;

  st_e        st;
  dbg_snap_t  live, held;
  logic       moved, capture, last;
  stall_res_e match_code;

  assign live    = '{w3: dbg3_i, w4: dbg4_i, w5: dbg5_i, w6: dbg6_i};
  assign capture = (st == ST_IDLE) && start_i && !skip_i;

  stall_snapshot u_snap (
    .clk(clk), .rst(rst), .capture(capture),
    .live(live), .held(held), .moved(moved)
  );

  stall_window_counter #(.HOLD(HOLD)) u_win (
    .clk(clk), .rst(rst), .clear(capture),
    .enable(st == ST_WATCH), .last(last)
  );

  stall_sig_matcher u_match (
    .snap(held), .code(match_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      done_o   <= 1'b0;
      result_o <= RES_NONE;
    end else begin
      done_o <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_i) begin
            if (skip_i) begin
              done_o   <= 1'b1;
              result_o <= RES_NONE;
            end else begin
              st <= ST_WATCH;
            end
          end
        end
        ST_WATCH: begin
          if (moved) begin
            done_o   <= 1'b1;
            result_o <= RES_NONE;
            st       <= ST_IDLE;
          end else if (last) begin
            done_o   <= 1'b1;
            result_o <= match_code;
            st       <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R7
  skip_fast_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && start_i && skip_i) |=> (done_o && result_o == 2'd0));

  // R2
  moved_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WATCH && moved) |=> (done_o && result_o == 2'd0 && st == ST_IDLE));

  // R3
  frozen_class_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WATCH && !moved && last) |=> (done_o && result_o != 2'd0));

  // R9
  window_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WATCH && !moved && !last) |=> (st == ST_WATCH && !done_o));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !(start_i && skip_i)) |=> !done_o);
endmodule

// File: tb/tb_dma_stall_classifier.sv
`timescale 1ns/1ps
module tb_dma_stall_classifier;
  localparam int HOLD = 50;

  typedef struct packed {
    logic [31:0] w3;
    logic [31:0] w4;
    logic [31:0] w5;
    logic [31:0] w6;
    logic        skip;
    logic [7:0]  chg;
    logic [1:0]  res;
  } vec_t;

  // chg = k: a word changes before the k-th compare edge (0 = frozen)
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{32'h0, 32'h0000_0006, 32'h0, 32'h0000_0001, 1'b0, 8'd0, 2'd1},  // R4 w4 field 0
    '{32'h0, 32'h0C00_0000, 32'h0, 32'h0000_0005, 1'b0, 8'd0, 2'd1},  // R4 w4 field 5, w6 upper ignored
    '{32'h0, 32'h0, 32'h0003_0000, 32'h0000_0001, 1'b0, 8'd0, 2'd1},  // R4 w5 field 3
    '{32'h0, 32'h0, 32'h0060_0000, 32'h0000_0001, 1'b0, 8'd0, 2'd3},  // R4 w5 bits above fields ignored
    '{32'h1224_0000, 32'h0, 32'h0, 32'h0, 1'b0, 8'd0, 2'd2},          // R5 signature 2
    '{32'h11E4_0000, 32'h0, 32'h0, 32'h0, 1'b0, 8'd0, 2'd3},          // R5 fetch wrong
    '{32'h1224_0000, 32'h0000_0006, 32'h0, 32'h0000_0001, 1'b0, 8'd0, 2'd1}, // R6 priority
    '{32'h0, 32'h0000_0006, 32'h0, 32'h0000_0002, 1'b0, 8'd0, 2'd3},  // R4 completion wrong
    '{32'h0, 32'h0, 32'h0, 32'h0, 1'b0, 8'd0, 2'd3},                  // R6 unknown
    '{32'h1224_0000, 32'h0, 32'h0, 32'h0, 1'b0, 8'd1, 2'd0},          // R2 change at first
    '{32'h1224_0000, 32'h0, 32'h0, 32'h0, 1'b0, 8'd25, 2'd0},         // R2 change mid
    '{32'h1224_0000, 32'h0, 32'h0, 32'h0, 1'b0, 8'd50, 2'd0},         // R2 change at last
    '{32'h0, 32'h0000_0006, 32'h0, 32'h0000_0001, 1'b1, 8'd0, 2'd0}   // R7 skip
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, skip_i = 1'b0;
  logic [31:0] dbg3_i = '0, dbg4_i = '0, dbg5_i = '0, dbg6_i = '0;
  logic done_o;
  logic [1:0] result_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_stall_classifier #(.HOLD(HOLD)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .skip_i(skip_i),
    .dbg3_i(dbg3_i), .dbg4_i(dbg4_i), .dbg5_i(dbg5_i), .dbg6_i(dbg6_i),
    .done_o(done_o), .result_o(result_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic run_vec(input vec_t v, input string req);
    int exp_at;
    bit early;
    @(negedge clk);
    start_i = 1'b1; skip_i = v.skip;
    dbg3_i = v.w3; dbg4_i = v.w4; dbg5_i = v.w5; dbg6_i = v.w6;
    @(negedge clk);
    start_i = 1'b0; skip_i = 1'b0;
    exp_at = v.skip ? 0 : ((v.chg != 0) ? int'(v.chg) : HOLD);
    early = 1'b0;
    for (int c = 0; c <= exp_at; c++) begin
      if (c < exp_at && done_o) early = 1'b1;
      if (c == exp_at) begin
        check(!early, {req, " no early done"}, early, 0);
        check(done_o == 1'b1, {req, " done due"}, done_o, 1);
        check(result_o == v.res, {req, " result"}, result_o, v.res);
      end else begin
        if (v.chg != 0 && c == int'(v.chg) - 1) dbg3_i = dbg3_i ^ 32'h1;
        @(negedge clk);
      end
    end
    @(negedge clk);
    check(done_o == 1'b0, "R8 done one cycle", done_o, 0);
    check(result_o == v.res, "R8 result held", result_o, v.res);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(done_o == 1'b0, "R1 done in reset", done_o, 0);
    check(result_o == 2'd0, "R1 result in reset", result_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check(done_o == 1'b0, "R1 done after reset", done_o, 0);
    check(result_o == 2'd0, "R1 result after reset", result_o, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], $sformatf("R3 vec%0d", i));

    // R9: start with skip in mid-window is ignored
    begin
      bit early = 1'b0;
      @(negedge clk);
      start_i = 1'b1; skip_i = 1'b0;
      dbg3_i = 32'h1224_0000; dbg4_i = '0; dbg5_i = '0; dbg6_i = '0;
      @(negedge clk);
      start_i = 1'b0;
      for (int c = 0; c < HOLD; c++) begin
        if (done_o) early = 1'b1;
        if (c == 10) begin start_i = 1'b1; skip_i = 1'b1; end
        else begin start_i = 1'b0; skip_i = 1'b0; end
        @(negedge clk);
      end
      start_i = 1'b0; skip_i = 1'b0;
      check(!early, "R9 no done from mid-window start", early, 0);
      check(done_o == 1'b1, "R9 done at window end", done_o, 1);
      check(result_o == 2'd2, "R9 result", result_o, 2);
    end

    // R1: reset mid-window clears outputs and aborts
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(done_o == 1'b0 && result_o == 2'd0, "R1 reset mid-window", result_o, 0);
    repeat (HOLD + 2) begin
      @(negedge clk);
      if (done_o) check(1'b0, "R1 no done after reset", 1, 0);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule